// File: doc/BRIEF.md
# Master-Mode Audio Frame Clock Generator

This block produces the serial audio timing for a converter pair running as timing master. From a single master clock it derives a bit clock at half the master clock rate and two left/right frame clocks, one for the ADC path and one for the DAC path. Each frame clock has its own 3-bit rate code that sets how many master clocks make one frame. The supported ratios include the non-power-of-two values 192, 384 and 768.

Each frame clock is high for the first half of its frame and low for the second half. Every frame edge falls on a falling edge of the bit clock, so downstream shifters can treat the bit clock as their data clock. A one-cycle start strobe marks the first master clock of every frame on each side. A new rate code takes effect only at the next frame boundary. No shortened frame is ever produced, and the two sides run independently of each other.

Top module: `audio_frame_clkgen`

## Requirements
- R1: While rst_n is low, every output (bit clock, both frame clocks, both start strobes) is 0.
- R2: From the first master clock edge after reset release, the bit clock is 0 and then toggles on every master clock edge, so it runs at half the master clock rate with a 50% duty cycle.
- R3: The rate code selects the frame length in master clocks as follows: 3'b000=128, 3'b001=192, 3'b010=256, 3'b011=384, 3'b100=512 and 3'b101=768. The reserved codes 3'b110 and 3'b111 select 256.
- R4: Within a frame, the frame clock is 1 for the first ratio/2 master clocks and 0 for the remaining ratio/2.
- R5: A frame clock changes only on a master clock edge at which the bit clock goes from 1 to 0.
- R6: Each start strobe is 1 for exactly one master clock, the first of each frame, which is the cycle in which its frame clock rises. This includes the first frame after reset.
- R7: A side samples its rate code only at the edge that begins a new frame, either the first edge after reset or the edge after the last cycle of a frame. A code change in mid-frame does not alter the length of the frame in progress.
- R8: The ADC and DAC sides are independent: each uses only its own rate code, and both frames start on the same first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_rate_code | input | 3 | Frame-length code for the ADC side |
| dac_rate_code | input | 3 | Frame-length code for the DAC side |
| bit_clk | output | 1 | Bit clock, master clock divided by 2 |
| adc_frame_clk | output | 1 | ADC left/right frame clock |
| dac_frame_clk | output | 1 | DAC left/right frame clock |
| adc_frame_start | output | 1 | One-cycle pulse on the first cycle of an ADC frame |
| dac_frame_start | output | 1 | One-cycle pulse on the first cycle of a DAC frame |

## Verification
A corrupted position counter or latched ratio shows up at the frame clock pins as a misplaced edge within one frame, at most 768 master clocks. The same fault also places a start strobe away from a rising frame edge. A stale or early latch of the rate code shows up as a frame whose length differs from the code present at its starting edge. This is visible on the first such frame. A bit clock out of step with the frame counters appears as a frame edge that does not coincide with a bit clock fall, and it is flagged on the very edge where it happens.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int RATE_W     = 3;
  localparam int BASE_RATIO = 128;
  localparam int MAX_RATIO  = 768;
  localparam int CNT_W      = $clog2(MAX_RATIO + 1);
  localparam int NUM_SIDES  = 2;

  typedef logic [RATE_W-1:0] rate_code_t;
  typedef logic [CNT_W-1:0]  ratio_t;

  // Odd codes are 1.5x the even code below them; each step of code[2:1] doubles.
  function automatic ratio_t code_to_ratio(input rate_code_t code);
    ratio_t base;
    if (code[2] && code[1]) begin
      code_to_ratio = ratio_t'(2 * BASE_RATIO);
    end else begin
      base = code[0] ? ratio_t'(BASE_RATIO + BASE_RATIO / 2) : ratio_t'(BASE_RATIO);
      code_to_ratio = base << code[2:1];
    end
  endfunction
endpackage

// File: rtl/afc_rate_decode.sv
module afc_rate_decode
  import afc_pkg::*;
(
  input  rate_code_t code_i,
  output ratio_t     ratio_o
);
  always_comb begin
    ratio_o = code_to_ratio(code_i);
  end
endmodule

// File: rtl/afc_bitclk_div.sv
module afc_bitclk_div (
  input  logic clk,
  input  logic rst_n,
  output logic bclk_o
);
  logic started_q, started_d;
  logic bclk_q, bclk_d;
  logic en;

  assign en = 1'b1;

  always_comb begin
    started_d = 1'b1;
    bclk_d    = started_q ? ~bclk_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      bclk_q    <= 1'b0;
    end else if (en) begin
      started_q <= started_d;
      bclk_q    <= bclk_d;
    end
  end

  assign bclk_o = bclk_q;
endmodule

// File: rtl/afc_frame_div.sv
module afc_frame_div
  import afc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_i,
  output logic   fclk_o,
  output logic   start_o
);
  logic   run_q, run_d;
  ratio_t pos_q, pos_d;
  ratio_t len_q, len_d;
  logic   fclk_q, fclk_d;
  logic   start_q, start_d;
  logic   boundary;
  ratio_t half_d;
  logic   en;

  assign en = 1'b1;

  always_comb begin
    boundary = !run_q || (pos_q == len_q - ratio_t'(1));
    run_d    = 1'b1;
    len_d    = boundary ? ratio_i : len_q;
    pos_d    = boundary ? '0 : pos_q + ratio_t'(1);
    half_d   = len_d >> 1;
    fclk_d   = pos_d < half_d;
    start_d  = boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pos_q   <= '0;
      len_q   <= ratio_t'(2 * BASE_RATIO);
      fclk_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (en) begin
      run_q   <= run_d;
      pos_q   <= pos_d;
      len_q   <= len_d;
      fclk_q  <= fclk_d;
      start_q <= start_d;
    end
  end

  assign fclk_o  = fclk_q;
  assign start_o = start_q;
endmodule

// File: rtl/audio_frame_clkgen.sv
module audio_frame_clkgen
  import afc_pkg::*;
(
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [2:0] adc_rate_code,
  input  logic [2:0] dac_rate_code,
  output logic       bit_clk,
  output logic       adc_frame_clk,
  output logic       dac_frame_clk,
  output logic       adc_frame_start,
  output logic       dac_frame_start
);
  rate_code_t codes [NUM_SIDES];
  logic       fclks [NUM_SIDES];
  logic       starts[NUM_SIDES];

  assign codes[0] = adc_rate_code;
  assign codes[1] = dac_rate_code;

  afc_bitclk_div u_bclk (
    .clk   (mclk),
    .rst_n (rst_n),
    .bclk_o(bit_clk)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    ratio_t ratio;

    afc_rate_decode u_dec (
      .code_i (codes[s]),
      .ratio_o(ratio)
    );

    afc_frame_div u_div (
      .clk    (mclk),
      .rst_n  (rst_n),
      .ratio_i(ratio),
      .fclk_o (fclks[s]),
      .start_o(starts[s])
    );
  end

  assign adc_frame_clk   = fclks[0];
  assign dac_frame_clk   = fclks[1];
  assign adc_frame_start = starts[0];
  assign dac_frame_start = starts[1];
endmodule

// File: rtl/afc_checker.sv
module afc_checker (
  input logic       mclk,
  input logic       rst_n,
  input logic       bit_clk,
  input logic       adc_frame_clk,
  input logic       dac_frame_clk,
  input logic       adc_frame_start,
  input logic       dac_frame_start
);
  logic [1:0] cyc_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n)            cyc_q <= 2'd0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  // R1: outputs held low in reset
  p_reset_low_r1: assert property (@(posedge mclk)
    !rst_n |-> !(bit_clk | adc_frame_clk | dac_frame_clk | adc_frame_start | dac_frame_start));

  p_bclk_toggle_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (bit_clk != $past(bit_clk)));

  p_adc_edge_on_fall_r5: assert property (@(posedge mclk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && adc_frame_clk != $past(adc_frame_clk)) |-> ($past(bit_clk) && !bit_clk));

  p_dac_edge_on_fall_r5: assert property (@(posedge mclk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && dac_frame_clk != $past(dac_frame_clk)) |-> ($past(bit_clk) && !bit_clk));

  p_adc_start_on_rise_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    (cyc_q >= 2'd1) |-> (adc_frame_start == (adc_frame_clk && !$past(adc_frame_clk))));

  p_dac_start_on_rise_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    (cyc_q >= 2'd1) |-> (dac_frame_start == (dac_frame_clk && !$past(dac_frame_clk))));

  // R4: a strobe only inside the high half
  p_start_in_high_r4: assert property (@(posedge mclk) disable iff (!rst_n)
    (adc_frame_start |-> adc_frame_clk) and (dac_frame_start |-> dac_frame_clk));

  // R8: both sides start together on the first edge after reset
  p_joint_first_frame_r8: assert property (@(posedge mclk) disable iff (!rst_n)
    (cyc_q == 2'd1) |-> (adc_frame_start && dac_frame_start));
endmodule

bind audio_frame_clkgen afc_checker u_afc_checker (
  .mclk           (mclk),
  .rst_n          (rst_n),
  .bit_clk        (bit_clk),
  .adc_frame_clk  (adc_frame_clk),
  .dac_frame_clk  (dac_frame_clk),
  .adc_frame_start(adc_frame_start),
  .dac_frame_start(dac_frame_start)
);

// File: tb/audio_frame_clkgen_test.sv
module audio_frame_clkgen_test;
  localparam int CLK_P = 10;
  localparam int WATCHDOG_CYC = 190000;

  typedef struct packed {
    logic bclk, afc, dfc, ast, dst, in_rst;
  } exp_t;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] adc_code = 3'b000;
  logic [2:0] dac_code = 3'b001;
  logic bit_clk, adc_fclk, dac_fclk, adc_start, dac_start;

  int checks = 0;
  int errors = 0;
  exp_t sb_q[$];

  audio_frame_clkgen uut (
    .mclk(mclk), .rst_n(rst_n),
    .adc_rate_code(adc_code), .dac_rate_code(dac_code),
    .bit_clk(bit_clk), .adc_frame_clk(adc_fclk), .dac_frame_clk(dac_fclk),
    .adc_frame_start(adc_start), .dac_frame_start(dac_start)
  );

  always #(CLK_P/2) mclk = ~mclk;

  // R3: frame lengths written out from the requirement table
  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b000: return 128;
      3'b001: return 192;
      3'b010: return 256;
      3'b011: return 384;
      3'b100: return 512;
      3'b101: return 768;
      default: return 256;
    endcase
  endfunction

  // Driver-side model: pushes expected outputs after every edge
  int  edges = 0;
  bit  a_run = 0, d_run = 0;
  int  a_pos = 0, d_pos = 0, a_len = 256, d_len = 256;
  bit  a_new, d_new;

  always @(posedge mclk) begin
    exp_t e;
    #1;
    if (!rst_n) begin
      edges = 0; a_run = 0; d_run = 0;
      e = '0; e.in_rst = 1'b1;
    end else begin
      edges++;
      a_new = !a_run || (a_pos == a_len - 1);
      if (a_new) begin a_pos = 0; a_len = len_of(adc_code); a_run = 1; end
      else a_pos++;
      d_new = !d_run || (d_pos == d_len - 1);
      if (d_new) begin d_pos = 0; d_len = len_of(dac_code); d_run = 1; end
      else d_pos++;
      e.in_rst = 1'b0;
      e.bclk = ((edges - 1) % 2) == 1;
      e.afc  = a_pos < a_len / 2;
      e.dfc  = d_pos < d_len / 2;
      e.ast  = a_new;
      e.dst  = d_new;
    end
    sb_q.push_back(e);
  end

  task automatic check1(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", what, $time, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares away from the active edge
  logic prev_bclk = 1'b0, prev_afc = 1'b0, prev_dfc = 1'b0;
  bit   prev_valid = 0;
  always @(negedge mclk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      if (e.in_rst) begin
        check1(bit_clk | adc_fclk | dac_fclk | adc_start | dac_start, 1'b0, "R1 outputs in reset");
      end else begin
        check1(bit_clk,   e.bclk, "R2 bit clock");
        check1(adc_fclk,  e.afc,  "R3 R4 R7 R8 adc frame clock");
        check1(dac_fclk,  e.dfc,  "R3 R4 R7 R8 dac frame clock");
        check1(adc_start, e.ast,  "R6 adc frame start");
        check1(dac_start, e.dst,  "R6 dac frame start");
        if (prev_valid && (adc_fclk != prev_afc || dac_fclk != prev_dfc))
          check1(prev_bclk & ~bit_clk, 1'b1, "R5 frame edge on bit clock fall");
      end
      prev_valid = !e.in_rst;
      prev_bclk = bit_clk; prev_afc = adc_fclk; prev_dfc = dac_fclk;
    end
  end

  task automatic run_cycles(input int n);
    repeat (n) @(negedge mclk);
    #1;
  endtask

  task automatic set_codes(input logic [2:0] a, input logic [2:0] d);
    adc_code = a;
    dac_code = d;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * WATCHDOG_CYC);
    errors++;
    $display("FAIL watchdog expired at %0t: actual=hung expected=done", $time);
    finish_run();
  end

  initial begin
    run_cycles(4);                  // R1: reset held
    rst_n = 1'b1;
    run_cycles(1000);               // R8: different codes per side
    for (int i = 0; i < 8; i++) begin   // R3: every code incl reserved
      set_codes(3'(i), 3'(7 - i));
      run_cycles(1600);
    end
    rst_n = 1'b0;                   // R1: mid-run reset
    run_cycles(3);
    set_codes(3'b101, 3'b011);
    rst_n = 1'b1;
    run_cycles(2000);
    for (int k = 0; k < 120; k++) begin // R7: codes change mid-frame
      set_codes(3'((k * 5) % 8), 3'((k * 3 + 1) % 8));
      run_cycles(37 + (k % 11));
    end
    run_cycles(1600);
    finish_run();
  end
endmodule